// File: doc/BRIEF.md
# Two-Slave Hierarchical Crossbar Switch

This block joins nine requesting channels to two targets: a memory-controller port (slave 0) and an I/O bus-master port (slave 1). Three channels belong to the processor and attach straight to the switch: instruction read, data read and data write. The other six form two groups of three. Each group holds two DMA channels and one external bus-slave target. Inside each group, a 3-to-1 pre-selector chooses one member and presents it to the switch as a single input. The switch therefore sees five inputs. Each slave has its own 5-to-1 selector and its own arbiter, so one transfer to memory and one transfer to I/O can be in progress in the same cycle.

Every channel uses the same handshake. The channel raises a request and holds it, together with its address, write flag and 128-bit write data, until it sees its done strobe. In the done cycle it receives read data. An address decode picks the target slave. Addresses inside a configured inclusive window go to memory, and all other addresses go to I/O. A slave sees its request held from the cycle after its grant until the cycle in which it returns done.

Top module: `xbar_2s`

## Requirements
- R1: After reset, and before any channel requests, `s_req`, `m_gnt` and `m_done` are all zero.
- R2: A transfer whose address lies in [MEM_LO, MEM_HI], bounds included, is served by slave 0 (memory). Any other address is served by slave 1 (I/O).
- R3: Two transfers that target different slaves are both in progress at the same time, and neither waits for the other.
- R4: Transfers that target the same slave are served one after another. The second is granted only after the slave's done for the first.
- R5: In the cycle a slave raises `s_done`, the owning channel sees `m_done` and that slave's read data on `m_rdata`. The slave's request drops in the following cycle.
- R6: While a slave is busy, its grant and the forwarded address, write flag and write data stay with one owner until done.
- R7: Each slave arbiter is round-robin over switch inputs 0..4 (instruction read, data read, data write, group A, group B). After reset the search starts at input 0. After each grant it starts one past the last winner.
- R8: Each pre-selector is round-robin over its members in the order DMA 0, DMA 1, external target (channel indices 3,4,5 for group A and 6,7,8 for group B). After reset it starts at DMA 0. It stays locked on its chosen member until that member's transfer is done.
- R9: The external bus-slave target in either group can reach both memory and I/O.
- R10: All 128 bits of write data arrive unchanged at the selected slave.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| m_req | input | 9 | Request per channel (0 ifetch, 1 dread, 2 dwrite, 3-5 group A, 6-8 group B) |
| m_we | input | 9 | Write flag per channel |
| m_addr | input | 9*AW | Address per channel, channel j at bits j*AW |
| m_wdata | input | 9*DW | Write data per channel |
| m_gnt | output | 9 | Channel currently owns a slave |
| m_done | output | 9 | Transfer complete strobe per channel |
| m_rdata | output | 9*DW | Read data per channel, valid with m_done |
| s_req | output | 2 | Request to slave 0 (memory) and slave 1 (I/O) |
| s_we | output | 2 | Write flag per slave |
| s_addr | output | 2*AW | Address per slave |
| s_wdata | output | 2*DW | Write data per slave |
| s_done | input | 2 | Done strobe from each slave |
| s_rdata | input | 2*DW | Read data from each slave |

## Verification
The bench builds the block with AW=32 and DW=128. It narrows the memory window to 0x1000..0x1FFF, so small addresses land on both sides of each decode boundary. A model of each slave returns read data derived from the address and the slave number, and the two slaves have different latencies. With these latencies, overlap and serialization show up clearly in the completion times, and the service order recorded at a slave exposes both round-robin rotations.

// File: rtl/xbar_2s.sv
module xbar_2s #(
  parameter int AW = 32,
  parameter int DW = 128,
  parameter logic [AW-1:0] MEM_LO = '0,
  parameter logic [AW-1:0] MEM_HI = {4'h0, {(AW-4){1'b1}}}
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [8:0]        m_req,
  input  logic [8:0]        m_we,
  input  logic [9*AW-1:0]   m_addr,
  input  logic [9*DW-1:0]   m_wdata,
  output logic [8:0]        m_gnt,
  output logic [8:0]        m_done,
  output logic [9*DW-1:0]   m_rdata,
  output logic [1:0]        s_req,
  output logic [1:0]        s_we,
  output logic [2*AW-1:0]   s_addr,
  output logic [2*DW-1:0]   s_wdata,
  input  logic [1:0]        s_done,
  input  logic [2*DW-1:0]   s_rdata
);
  localparam int NX = 5;

  function automatic logic [2:0] rr_pick(input logic [4:0] r, input logic [2:0] last, input int n);
    int idx;
    rr_pick = last;
    for (int i = n; i >= 1; i--) begin
      idx = (int'(last) + i) % n;
      if (r[idx]) rr_pick = 3'(idx);
    end
  endfunction

  logic          pv    [2];
  logic [1:0]    po    [2];
  logic [1:0]    plast [2];
  logic [1:0]    ppick [2];
  logic [1:0]    psel  [2];
  logic          busy  [2];
  logic [2:0]    own   [2];
  logic [2:0]    slast [2];
  logic [2:0]    spick [2];
  logic [4:0]    want  [2];
  logic [3:0]    xs     [NX];
  logic          x_req  [NX];
  logic          x_we   [NX];
  logic [AW-1:0] x_addr [NX];
  logic [DW-1:0] x_wdata[NX];
  logic [DW-1:0] x_rdata[NX];
  logic [NX-1:0] xdone, xgnt;

  always_comb begin
    logic [2:0] tmp;
    for (int p = 0; p < 2; p++) begin
      tmp = rr_pick({2'b00, m_req[3+3*p +: 3]}, {1'b0, plast[p]}, 3);
      ppick[p] = tmp[1:0];
      psel[p]  = pv[p] ? po[p] : ppick[p];
    end
    for (int i = 0; i < 3; i++) xs[i] = 4'(i);
    xs[3] = 4'd3 + {2'b00, psel[0]};
    xs[4] = 4'd6 + {2'b00, psel[1]};
    want[0] = '0;
    want[1] = '0;
    for (int i = 0; i < NX; i++) begin
      x_req[i]   = m_req[xs[i]];
      x_we[i]    = m_we[xs[i]];
      x_addr[i]  = m_addr[xs[i]*AW +: AW];
      x_wdata[i] = m_wdata[xs[i]*DW +: DW];
      if (x_addr[i] >= MEM_LO && x_addr[i] <= MEM_HI) want[0][i] = x_req[i];
      else                                            want[1][i] = x_req[i];
    end
    for (int k = 0; k < 2; k++) spick[k] = rr_pick(want[k], slast[k], NX);
    for (int i = 0; i < NX; i++) begin
      xgnt[i]    = 1'b0;
      xdone[i]   = 1'b0;
      x_rdata[i] = s_rdata[DW-1:0];
      for (int k = 0; k < 2; k++)
        if (busy[k] && own[k] == 3'(i)) begin
          xgnt[i]    = 1'b1;
          xdone[i]   = s_done[k];
          x_rdata[i] = s_rdata[k*DW +: DW];
        end
    end
    m_gnt   = '0;
    m_done  = '0;
    m_rdata = '0;
    for (int i = 0; i < NX; i++) begin
      m_gnt[xs[i]]  = xgnt[i];
      m_done[xs[i]] = xdone[i];
      m_rdata[xs[i]*DW +: DW] = x_rdata[i];
    end
    for (int k = 0; k < 2; k++) begin
      s_req[k] = busy[k];
      s_we[k]  = busy[k] & x_we[own[k]];
      s_addr[k*AW +: AW]  = x_addr[own[k]];
      s_wdata[k*DW +: DW] = x_wdata[own[k]];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int p = 0; p < 2; p++) begin
        pv[p] <= 1'b0; po[p] <= 2'd0; plast[p] <= 2'd2;
      end
      for (int k = 0; k < 2; k++) begin
        busy[k] <= 1'b0; own[k] <= 3'd0; slast[k] <= 3'd4;
      end
    end else begin
      for (int p = 0; p < 2; p++) begin
        if (pv[p]) begin
          if (xdone[3+p]) pv[p] <= 1'b0;
        end else if (|m_req[3+3*p +: 3]) begin
          pv[p] <= 1'b1; po[p] <= ppick[p]; plast[p] <= ppick[p];
        end
      end
      for (int k = 0; k < 2; k++) begin
        if (busy[k]) begin
          if (s_done[k]) busy[k] <= 1'b0;
        end else if (|want[k]) begin
          busy[k] <= 1'b1; own[k] <= spick[k]; slast[k] <= spick[k];
        end
      end
    end
  end

  a_r2_mem_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_req[0] |-> (s_addr[AW-1:0] >= MEM_LO && s_addr[AW-1:0] <= MEM_HI));
  a_r2_io_window: assert property (@(posedge clk) disable iff (!rst_n)
    s_req[1] |-> !(s_addr[2*AW-1:AW] >= MEM_LO && s_addr[2*AW-1:AW] <= MEM_HI));
  a_r3_two_owners: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(m_gnt) <= 2);

  generate
    for (genvar k = 0; k < 2; k++) begin : g_chk
      a_r6_hold_owner: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req[k] && !s_done[k]) |=> (s_req[k] && $stable(own[k]) && $stable(s_addr[k*AW +: AW])));
      a_r5_release: assert property (@(posedge clk) disable iff (!rst_n)
        (s_req[k] && s_done[k]) |=> !s_req[k]);
      a_r8_pre_lock: assert property (@(posedge clk) disable iff (!rst_n)
        (pv[k] && !xdone[3+k]) |=> (pv[k] && $stable(po[k])));
    end
  endgenerate
endmodule

// File: tb/sim_xbar_2s.sv
module sim_xbar_2s;
  localparam int AW = 32, DW = 128;
  localparam int LAT0 = 3, LAT1 = 4;

  logic clk = 0, rst_n = 0;
  logic [8:0] m_req = '0, m_we = '0;
  logic [9*AW-1:0] m_addr = '0;
  logic [9*DW-1:0] m_wdata = '0;
  logic [8:0] m_gnt, m_done;
  logic [9*DW-1:0] m_rdata;
  logic [1:0] s_req, s_we;
  logic [2*AW-1:0] s_addr;
  logic [2*DW-1:0] s_wdata;
  logic [1:0] s_done = '0;
  logic [2*DW-1:0] s_rdata = '0;

  xbar_2s #(.AW(AW), .DW(DW), .MEM_LO(32'h1000), .MEM_HI(32'h1FFF)) u0 (
    .clk(clk), .rst_n(rst_n), .m_req(m_req), .m_we(m_we), .m_addr(m_addr),
    .m_wdata(m_wdata), .m_gnt(m_gnt), .m_done(m_done), .m_rdata(m_rdata),
    .s_req(s_req), .s_we(s_we), .s_addr(s_addr), .s_wdata(s_wdata),
    .s_done(s_done), .s_rdata(s_rdata));

  always #10 clk = ~clk;

  int cyc = 0, total = 0, bad = 0;
  bit fin = 0;
  always @(posedge clk) cyc <= cyc + 1;

  function automatic logic [127:0] pat(input int k, input logic [31:0] a);
    return {4{a ^ (k == 1 ? 32'hB0B0_0000 : 32'h0C0C_0000)}};
  endfunction

  int cnt [2] = '{0, 0};
  int nlog [2] = '{0, 0};
  logic [31:0] alog [2][32];
  logic [127:0] wlog [2];
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (rst_n && s_req[k] && !s_done[k]) begin
        if (cnt[k] == (k == 0 ? LAT0 : LAT1) - 1) begin
          s_done[k] <= 1'b1;
          s_rdata[k*DW +: DW] <= pat(k, s_addr[k*AW +: AW]);
          alog[k][nlog[k] % 32] <= s_addr[k*AW +: AW];
          if (s_we[k]) wlog[k] <= s_wdata[k*DW +: DW];
          nlog[k] <= nlog[k] + 1;
          cnt[k] <= 0;
        end else cnt[k] <= cnt[k] + 1;
      end else s_done[k] <= 1'b0;
    end
  end

  task automatic chk(input bit ok, input string r, input logic [127:0] act, input logic [127:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", r, act, exp);
    end
  endtask

  task automatic xfer(input int j, input logic [31:0] a, input logic we, input logic [127:0] wd,
                      output logic [127:0] rd, output int t);
    @(negedge clk);
    m_addr[j*AW +: AW] = a;
    m_we[j] = we;
    m_wdata[j*DW +: DW] = wd;
    m_req[j] = 1'b1;
    forever begin
      @(negedge clk); #1;
      if (m_done[j]) break;
    end
    rd = m_rdata[j*DW +: DW];
    t = cyc;
    m_req[j] = 1'b0;
  endtask

  task automatic t_reset;
    chk(s_req == 0, "R1 s_req", 128'(s_req), 0);
    chk(m_gnt == 0, "R1 m_gnt", 128'(m_gnt), 0);
    chk(m_done == 0, "R1 m_done", 128'(m_done), 0);
  endtask

  task automatic t_decode;
    logic [31:0] addrs [4] = '{32'h0FFF, 32'h1000, 32'h1FFF, 32'h2000};
    int sl [4] = '{1, 0, 0, 1};
    for (int n = 0; n < 4; n++) begin
      logic [127:0] rd; int t, b0, b1;
      b0 = nlog[0]; b1 = nlog[1];
      xfer(0, addrs[n], 1'b0, '0, rd, t);
      chk(rd == pat(sl[n], addrs[n]), "R2 decode rdata", rd, pat(sl[n], addrs[n]));
      chk((sl[n] == 0 ? nlog[0] - b0 : nlog[1] - b1) == 1, "R5 served by decoded slave",
          128'(sl[n] == 0 ? nlog[0] - b0 : nlog[1] - b1), 1);
    end
  endtask

  task automatic t_parallel;
    logic [127:0] r0, r2, wd; int t0, t2;
    wd = 128'hDEAD_BEEF_0123_4567_89AB_CDEF_F00D_CAFE;
    fork
      xfer(0, 32'h1100, 1'b0, '0, r0, t0);
      xfer(2, 32'h3300, 1'b1, wd, r2, t2);
    join
    chk(r0 == pat(0, 32'h1100), "R3 mem rdata", r0, pat(0, 32'h1100));
    chk(wlog[1] == wd, "R10 io write data", wlog[1], wd);
    chk(alog[1][(nlog[1] - 1) % 32] == 32'h3300, "R6 io address", 128'(alog[1][(nlog[1] - 1) % 32]), 128'h3300);
    chk((t2 - t0) <= 2 && (t0 - t2) <= 2, "R3 overlap", 128'(t2 - t0), 1);
  endtask

  task automatic t_serial;
    logic [127:0] r1, r2, wd; int t1, t2, d;
    wd = {4{32'h5555_AAAA}};
    fork
      xfer(1, 32'h1200, 1'b0, '0, r1, t1);
      xfer(2, 32'h1300, 1'b1, wd, r2, t2);
    join
    d = (t2 > t1) ? t2 - t1 : t1 - t2;
    chk(d >= LAT0, "R4 serialized", 128'(d), 128'(LAT0));
    chk(r1 == pat(0, 32'h1200), "R4 dread rdata", r1, pat(0, 32'h1200));
    chk(wlog[0] == wd, "R10 mem write data", wlog[0], wd);
  endtask

  task automatic t_rr_slave;
    int b; logic [31:0] exp [4] = '{32'h1A00, 32'h1B00, 32'h1A04, 32'h1B04};
    b = nlog[0];
    fork
      begin logic [127:0] r; int t; xfer(1, 32'h1A00, 0, '0, r, t); xfer(1, 32'h1A04, 0, '0, r, t); end
      begin logic [127:0] r; int t; xfer(2, 32'h1B00, 0, '0, r, t); xfer(2, 32'h1B04, 0, '0, r, t); end
    join
    for (int n = 0; n < 4; n++)
      chk(alog[0][(b + n) % 32] == exp[n], "R7 slave round robin order",
          128'(alog[0][(b + n) % 32]), 128'(exp[n]));
  endtask

  task automatic t_presel;
    int b; logic [31:0] exp [3] = '{32'h1C00, 32'h1C10, 32'h1C20};
    logic [127:0] r3, r4, r5; int t3, t4, t5;
    b = nlog[0];
    fork
      xfer(3, 32'h1C00, 0, '0, r3, t3);
      xfer(4, 32'h1C10, 0, '0, r4, t4);
      xfer(5, 32'h1C20, 0, '0, r5, t5);
    join
    for (int n = 0; n < 3; n++)
      chk(alog[0][(b + n) % 32] == exp[n], "R8 preselector order",
          128'(alog[0][(b + n) % 32]), 128'(exp[n]));
    chk(r5 == pat(0, 32'h1C20), "R8 ext member rdata", r5, pat(0, 32'h1C20));
  endtask

  task automatic t_ext_both;
    logic [127:0] ra, rb; int ta, tb;
    fork
      xfer(5, 32'h4000, 0, '0, ra, ta);
      xfer(8, 32'h1D00, 0, '0, rb, tb);
    join
    chk(ra == pat(1, 32'h4000), "R9 ext A to io", ra, pat(1, 32'h4000));
    chk(rb == pat(0, 32'h1D00), "R9 ext B to mem", rb, pat(0, 32'h1D00));
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk); #1;
    t_reset();
    t_decode();
    t_parallel();
    t_serial();
    t_rr_slave();
    t_presel();
    t_ext_both();
    repeat (3) @(negedge clk);
    fin = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!fin) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule